// File: doc/BRIEF.md
# SPI Flash Page-Program Sequencer

This block turns one host write request into the series of serial-flash transactions needed to store it. The request gives a start offset, a byte count and a byte stream. The block cuts the request into chunks so that no chunk crosses a flash page. When a nonzero transfer limit is configured, that limit also caps each chunk.

Each chunk's logical address is translated before it is sent. In two-die stacked mode, the upper half of the space moves onto the second die, and a registered select line tells the serializer which die to address. The block then picks a 16 MiB bank within that die. It keeps a copy of the last bank it programmed, and it rewrites the flash bank register only when the chunk needs a different bank.

Every register write and every page program is sent as its own frame. A one-byte write-enable frame always comes first. After the frame, the block starts an external status poller and waits for it to answer. A failure reported by the poller ends the request with an error.

Top module: `flash_prog_seq`

## Requirements
- R1: Each chunk carries the smaller of two counts: the bytes still owed, and PAGE_BYTES minus (offset mod PAGE_BYTES). PAGE_BYTES is a power of two.
- R2: When MAX_XFER is nonzero, no chunk carries more than MAX_XFER bytes.
- R3: In stacked mode, an offset at or above TOTAL_BYTES/2 has TOTAL_BYTES/2 subtracted and drives `cs_upper` high for that chunk. Any lower offset drives `cs_upper` low. `cs_upper` is 0 after reset.
- R4: The bank index is the die-local address shifted right by 24.
- R5: A bank-register write is sent only when the bank index differs from the cached bank. Its sequence is a write-enable frame, then the frame {OP_BANKWR, bank byte}, then a poll. The cache takes the new index only when that poll succeeds. The cache is 0 after reset.
- R6: A program frame carries, in order: OP_PROG, local address bits 23:16, bits 15:8, bits 7:0, then the chunk's payload bytes. `cmd_last` is 1 only on the final byte of a frame.
- R7: Every program frame and every bank frame is preceded by the single-byte frame OP_WREN. Each is followed by a one-cycle `poll_start` with `poll_limit` equal to PROG_TIMEOUT.
- R8: A `poll_done` with `poll_fail` high ends the request. No further frames are sent, and `resp_valid` rises on the next cycle with `resp_err` = 1.
- R9: A request of length 0 gives `resp_valid` = 1 with `resp_err` = 0 in the cycle after acceptance, and no command byte is sent.
- R10: After reset, `req_ready` = 1, `cmd_valid` = 0 and `resp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this cycle |
| req_offset | input | ADDR_W | Logical start offset |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Payload byte taken |
| wr_data | input | 8 | Payload byte |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_err | output | 1 | Completion with failure |
| cmd_valid | output | 1 | Command byte present |
| cmd_ready | input | 1 | Serializer takes the byte |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Final byte of a frame (chip select released after it) |
| cs_upper | output | 1 | Upper-die select |
| poll_start | output | 1 | Start status poll |
| poll_limit | output | 32 | Timeout handed to the poller |
| poll_done | input | 1 | Poll finished |
| poll_fail | input | 1 | Poll timed out or failed |

## Verification
A zero-length request is accepted on one edge, and its response strobe is due right after that edge, with no stall cycle allowed. Each command byte counts at the edge where valid and ready are both high. The bench samples both at the falling edge and records the byte, with its frame-end flag and die select, at the rising edge that follows.

The poller answers a fixed three cycles after it sees `poll_start`. The response is due one cycle after `poll_done`, and the bench waits for that strobe before comparing the whole recorded byte stream against the stream its model predicts. A stalling ready pattern on the serializer side checks that no byte is lost or repeated when the flash side holds off.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CALC, S_WREN_B, S_BANK_OP, S_BANK_VAL, S_BPOLL_GO, S_BPOLL_WAIT,
    S_WREN_P, S_PROG_OP, S_ADDR2, S_ADDR1, S_ADDR0, S_DATA, S_PPOLL_GO,
    S_PPOLL_WAIT, S_RESP
  } seq_state_t;
endpackage

// File: rtl/flash_addr_map.sv
module flash_addr_map #(
  parameter int ADDR_W = 32,
  parameter longint unsigned TOTAL_BYTES = 64'h0400_0000,
  parameter bit DUAL = 1'b1,
  localparam int BANK_W = ADDR_W - 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] local_o,
  output logic              upper_o,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(TOTAL_BYTES / 2);

  generate
    if (DUAL) begin : g_stacked
      assign upper_o = (addr_i >= HALF);
      assign local_o = upper_o ? (addr_i - HALF) : addr_i;
    end else begin : g_single
      assign upper_o = 1'b0;
      assign local_o = addr_i;
    end
  endgenerate

  assign bank_o = local_o[ADDR_W-1:24];
endmodule

// File: rtl/flash_chunk_len.sv
module flash_chunk_len #(
  parameter int LEN_W = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_XFER = 0,
  localparam int PAGE_W = $clog2(PAGE_BYTES)
) (
  input  logic [PAGE_W-1:0] page_off_i,
  input  logic [LEN_W-1:0]  remain_i,
  output logic [LEN_W-1:0]  chunk_o
);
  logic [LEN_W-1:0] page_left, by_page;

  assign page_left = LEN_W'(PAGE_BYTES) - LEN_W'(page_off_i);
  assign by_page   = (remain_i < page_left) ? remain_i : page_left;

  generate
    if (MAX_XFER == 0) begin : g_nocap
      assign chunk_o = by_page;
    end else begin : g_cap
      assign chunk_o = (by_page > LEN_W'(MAX_XFER)) ? LEN_W'(MAX_XFER) : by_page;
    end
  endgenerate
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 16,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_XFER = 0,
  parameter longint unsigned TOTAL_BYTES = 64'h0400_0000,
  parameter bit DUAL = 1'b1,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_PROG = 8'h02,
  parameter logic [7:0] OP_BANKWR = 8'hC5,
  parameter logic [31:0] PROG_TIMEOUT = 32'd400000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              resp_valid,
  output logic              resp_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_data,
  output logic              cmd_last,
  output logic              cs_upper,
  output logic              poll_start,
  output logic [31:0]       poll_limit,
  input  logic              poll_done,
  input  logic              poll_fail
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BANK_W = ADDR_W - 24;

  seq_state_t state;
  logic [ADDR_W-1:0] off_q;
  logic [LEN_W-1:0]  rem_q, chunk_q, cnt_q;
  logic [23:0]       local_q;
  logic [BANK_W-1:0] bank_new_q, bank_cur_q;
  logic              err_q;

  logic [ADDR_W-1:0] map_local;
  logic              map_upper;
  logic [BANK_W-1:0] map_bank;
  logic [LEN_W-1:0]  calc_chunk;

  flash_addr_map #(.ADDR_W(ADDR_W), .TOTAL_BYTES(TOTAL_BYTES), .DUAL(DUAL)) i_map (
    .addr_i(off_q), .local_o(map_local), .upper_o(map_upper), .bank_o(map_bank)
  );

  flash_chunk_len #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_XFER(MAX_XFER)) i_chunk (
    .page_off_i(off_q[PAGE_W-1:0]), .remain_i(rem_q), .chunk_o(calc_chunk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      off_q      <= '0;
      rem_q      <= '0;
      chunk_q    <= '0;
      cnt_q      <= '0;
      local_q    <= '0;
      bank_new_q <= '0;
      bank_cur_q <= '0;
      cs_upper   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          off_q <= req_offset;
          rem_q <= req_len;
          err_q <= 1'b0;
          state <= (req_len == '0) ? S_RESP : S_CALC;
        end
        S_CALC: begin
          local_q    <= map_local[23:0];
          bank_new_q <= map_bank;
          chunk_q    <= calc_chunk;
          cs_upper   <= map_upper;
          state      <= (map_bank != bank_cur_q) ? S_WREN_B : S_WREN_P;
        end
        S_WREN_B:   if (cmd_ready) state <= S_BANK_OP;
        S_BANK_OP:  if (cmd_ready) state <= S_BANK_VAL;
        S_BANK_VAL: if (cmd_ready) state <= S_BPOLL_GO;
        S_BPOLL_GO: state <= S_BPOLL_WAIT;
        S_BPOLL_WAIT: if (poll_done) begin
          if (poll_fail) begin
            err_q <= 1'b1;
            state <= S_RESP;
          end else begin
            bank_cur_q <= bank_new_q;
            state      <= S_WREN_P;
          end
        end
        S_WREN_P:  if (cmd_ready) state <= S_PROG_OP;
        S_PROG_OP: if (cmd_ready) state <= S_ADDR2;
        S_ADDR2:   if (cmd_ready) state <= S_ADDR1;
        S_ADDR1:   if (cmd_ready) state <= S_ADDR0;
        S_ADDR0: if (cmd_ready) begin
          cnt_q <= chunk_q;
          state <= S_DATA;
        end
        S_DATA: if (cmd_ready && wr_valid) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) state <= S_PPOLL_GO;
        end
        S_PPOLL_GO: state <= S_PPOLL_WAIT;
        S_PPOLL_WAIT: if (poll_done) begin
          if (poll_fail) begin
            err_q <= 1'b1;
            state <= S_RESP;
          end else begin
            off_q <= off_q + ADDR_W'(chunk_q);
            rem_q <= rem_q - chunk_q;
            state <= (rem_q == chunk_q) ? S_RESP : S_CALC;
          end
        end
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid = 1'b1;
    cmd_data  = 8'h00;
    cmd_last  = 1'b0;
    case (state)
      S_WREN_B, S_WREN_P: begin cmd_data = OP_WREN; cmd_last = 1'b1; end
      S_BANK_OP:  cmd_data = OP_BANKWR;
      S_BANK_VAL: begin cmd_data = 8'(bank_new_q); cmd_last = 1'b1; end
      S_PROG_OP:  cmd_data = OP_PROG;
      S_ADDR2:    cmd_data = local_q[23:16];
      S_ADDR1:    cmd_data = local_q[15:8];
      S_ADDR0:    cmd_data = local_q[7:0];
      S_DATA: begin
        cmd_valid = wr_valid;
        cmd_data  = wr_data;
        cmd_last  = (cnt_q == LEN_W'(1));
      end
      default: cmd_valid = 1'b0;
    endcase
  end

  assign req_ready  = (state == S_IDLE);
  assign wr_ready   = (state == S_DATA) && cmd_ready;
  assign resp_valid = (state == S_RESP);
  assign resp_err   = err_q;
  assign poll_start = (state == S_BPOLL_GO) || (state == S_PPOLL_GO);
  assign poll_limit = PROG_TIMEOUT;

  logic [LEN_W:0] page_end;
  assign page_end = {1'b0, chunk_q} + (LEN_W+1)'(off_q[PAGE_W-1:0]);

  AST_CHUNK_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROG_OP) |-> (chunk_q != '0 && chunk_q <= rem_q && page_end <= (LEN_W+1)'(PAGE_BYTES))); // R1
  AST_CHUNK_CAPPED: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROG_OP && MAX_XFER != 0) |-> (chunk_q <= LEN_W'(MAX_XFER))); // R2
  AST_UPPER_AT_CALC: assert property (@(posedge clk) disable iff (rst)
    (cs_upper != $past(cs_upper)) |-> ($past(state) == S_CALC)); // R3
  AST_BANK_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (state == S_BANK_OP) |-> (bank_new_q != bank_cur_q)); // R5
  AST_CACHE_AFTER_OK: assert property (@(posedge clk) disable iff (rst)
    (bank_cur_q != $past(bank_cur_q)) |-> $past(state == S_BPOLL_WAIT && poll_done && !poll_fail)); // R5
  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROG_OP && $past(state) != S_PROG_OP) |-> ($past(state) == S_WREN_P)); // R7
  AST_STOP_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (poll_done && poll_fail && (state == S_PPOLL_WAIT || state == S_BPOLL_WAIT))
      |=> (resp_valid && resp_err && !cmd_valid)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> (resp_valid && !resp_err && !cmd_valid)); // R9
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int PAGE = 16;
  localparam int MAXX = 12;
  localparam logic [31:0] HALF = 32'h0200_0000;
  localparam logic [31:0] TMO = 32'd1234;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, wr_valid = 1'b1, cmd_ready = 1'b1;
  logic poll_done = 1'b0, poll_fail = 1'b0;
  logic [31:0] req_offset = '0;
  logic [15:0] req_len = '0;
  logic [7:0] data_ctr = 8'h00;
  logic req_ready, wr_ready, resp_valid, resp_err, cmd_valid, cmd_last, cs_upper, poll_start;
  logic [7:0] cmd_data;
  logic [31:0] poll_limit;

  flash_prog_seq #(.PAGE_BYTES(PAGE), .MAX_XFER(MAXX), .PROG_TIMEOUT(TMO)) i_flash_prog_seq (
    .clk, .rst, .req_valid, .req_ready, .req_offset, .req_len, .wr_valid, .wr_ready,
    .wr_data(data_ctr), .resp_valid, .resp_err, .cmd_valid, .cmd_ready, .cmd_data,
    .cmd_last, .cs_upper, .poll_start, .poll_limit, .poll_done, .poll_fail
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [9:0] got_q[$], exp_q[$];
  int poll_n = 0, fail_at = 0, poll_wait = 0, cyc = 0;
  bit poll_seen = 1'b0;
  logic [7:0] mbank = 8'h00;

  task automatic chk(input bit ok, input string req, input string what, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // monitor: sample at falling edge, commit at rising edge
  initial forever begin
    bit hs, dhs, ps;
    logic [9:0] ent;
    @(negedge clk);
    hs = cmd_valid && cmd_ready;
    dhs = hs && wr_ready;
    ent = {cs_upper, cmd_last, cmd_data};
    ps = poll_start;
    if (ps) chk(poll_limit == TMO, "R7", "poll_limit", poll_limit, TMO);
    @(posedge clk);
    if (hs) got_q.push_back(ent);
    if (ps) poll_seen = 1'b1;
    if (dhs) begin #1; data_ctr = data_ctr + 8'd1; end
  end

  // flash-side driver: stalling ready and fixed-latency poller
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    cmd_ready = (cyc % 5) != 4;
    poll_done = 1'b0;
    poll_fail = 1'b0;
    if (poll_wait > 0) begin
      poll_wait--;
      if (poll_wait == 0) begin
        poll_done = 1'b1;
        poll_fail = (poll_n == fail_at);
      end
    end
    if (poll_seen) begin
      poll_seen = 1'b0;
      poll_n++;
      poll_wait = 3;
    end
  end

  task automatic build_exp(input logic [31:0] off, input int len, output bit err);
    int rem = len, polls = 0;
    logic [7:0] d = data_ctr;
    err = 1'b0;
    exp_q.delete();
    while (rem > 0) begin
      bit up = off >= HALF;
      logic [31:0] loc = up ? off - HALF : off;
      logic [7:0] bank = loc[31:24];
      int ch = PAGE - int'(off % PAGE);
      if (rem < ch) ch = rem;
      if (ch > MAXX) ch = MAXX;
      if (bank != mbank) begin
        exp_q.push_back({up, 1'b1, 8'h06});
        exp_q.push_back({up, 1'b0, 8'hC5});
        exp_q.push_back({up, 1'b1, bank});
        polls++;
        if (polls == fail_at) begin err = 1'b1; break; end
        mbank = bank;
      end
      exp_q.push_back({up, 1'b1, 8'h06});
      exp_q.push_back({up, 1'b0, 8'h02});
      exp_q.push_back({up, 1'b0, loc[23:16]});
      exp_q.push_back({up, 1'b0, loc[15:8]});
      exp_q.push_back({up, 1'b0, loc[7:0]});
      for (int i = 0; i < ch; i++) begin
        exp_q.push_back({up, (i == ch - 1), d});
        d = d + 8'd1;
      end
      polls++;
      if (polls == fail_at) begin err = 1'b1; break; end
      off = off + 32'(ch);
      rem = rem - ch;
    end
  endtask

  task automatic run_req(input logic [31:0] off, input int len, input int fail_n, input string req);
    bit exp_err;
    int w = 0;
    fail_at = fail_n;
    poll_n = 0;
    build_exp(off, len, exp_err);
    got_q.delete();
    @(negedge clk);
    chk(req_ready == 1'b1, req, "req_ready idle", req_ready, 1);
    req_valid = 1'b1; req_offset = off; req_len = 16'(len);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!resp_valid && w < 5000) begin @(negedge clk); w++; end
    if (len == 0) chk(w == 0, "R9", "response latency", w, 0);
    if (w >= 5000) chk(1'b0, req, "response timeout", 0, 1);
    @(negedge clk);
    chk(resp_err == exp_err, req, "resp_err", resp_err, exp_err);
    chk(got_q.size() == exp_q.size(), req, "byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] != exp_q[i]) begin
        chk(1'b0, req, $sformatf("byte %0d {upper,last,data}", i), got_q[i], exp_q[i]);
        break;
      end
    checks++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R10", "cmd_valid", cmd_valid, 0);
    chk(resp_valid == 1'b0, "R10", "resp_valid", resp_valid, 0);
    chk(cs_upper == 1'b0, "R3", "cs_upper reset", cs_upper, 0);
    run_req(32'h0, 0, 0, "R9");                  // zero length, no bytes
    run_req(32'h5, 20, 0, "R1");                 // page split 11 + 9
    run_req(32'h40, 30, 0, "R2");                // cap at 12: 12,4? no: 12,4,12,2
    run_req(32'h00FF_FFFC, 10, 0, "R4");         // crosses into bank 1, R5 bank write
    run_req(32'h0200_0008, 4, 0, "R3");          // upper die, bank back to 0 (R5)
    run_req(32'h0300_0000, 3, 0, "R5");          // upper die bank 1 write
    run_req(32'h0300_0010, 5, 0, "R6");          // same bank, no bank frame
    run_req(32'h0, 30, 2, "R8");                 // bank ok, first program poll fails
    run_req(32'h0000_0020, 4, 0, "R5");          // cache now 0, no bank frame
    run_req(32'h0100_0000, 2, 1, "R8");          // bank write poll fails
    run_req(32'h0100_0000, 2, 0, "R5");          // cache not updated: bank frame again
    run_req(32'h0000_0007, 1, 0, "R7");          // single byte, bank change back to 0
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired: got 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule